// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block connects a 17-bit local bus (side A) to a 17-bit backplane (side B), with one data path in each direction. Each path holds its data in one storage element that has three modes. In pass mode the input goes straight through to the output. In latched mode the element keeps the value that was present when its pass control dropped. In clocked mode the element captures the input on a rising edge of that path's strobe, but only while the path's active-low capture enable is asserted. Every control input is sampled on the block clock `clk`, and a strobe edge is detected when the strobe is sampled low at one clock edge and high at the next.

The A side drives a three-state bus, modelled as a data vector plus one output enable. The B side is open drain: each bit has a pull-low enable, and the board resolves the wire with a pull-up, so several drivers form a wired-OR. The A-to-B strobe is forwarded to the backplane as a clock output, timed so that it never rises before the B data it marks. The B-to-A strobe is forwarded to the A side in the same way. Each direction has its own active-low output enable, and that enable also gates the direction's forwarded clock. The pins are plain level controls. There is no valid/ready handshake, because the bus itself applies no back-pressure.

Top module: `xcvr_bidir`

## Requirements
- R1: Both data paths are `W` bits wide, with W defaulting to 17. The widths of `a_in`, `a_out`, `b_in` and `b_pull` are all `W`.
- R2: While a path's pass control (`ab_pass` / `ba_pass`) is high, that path's stored output equals its present input in the same cycle, with no clock delay.
- R3: At the first clock edge where the pass control is sampled low after being high, the output keeps the input that was sampled at the last edge where the pass control was high.
- R4: While the pass control is low, a strobe edge (strobe sampled 0, then 1) at a clock edge where the capture enable (`*_cap_n`) is 0 loads the input sampled at that clock edge. The new value appears on the output right after that edge.
- R5: While the pass control is low, the stored value does not change when the capture enable is 1 or when no strobe edge occurs.
- R6: A high pass control takes priority over a clocked capture.
- R7: `a_oe` is the inverse of `ba_oe_n`. `a_out` always shows the stored B-to-A value.
- R8: `b_pull[i]` is 1 exactly when `ab_oe_n` is 0 and stored A-to-B bit i is 0. When the wire is resolved with a pull-up, it shows the stored value while the output is enabled and all ones while it is disabled.
- R9: `b_clk_out` equals `ab_strobe` delayed by one clock, forced to 0 while `ab_oe_n` is 1. It rises in the same cycle that a clocked capture first appears on `b_pull`, never before it.
- R10: `a_clk_out` equals `ba_strobe` delayed by one clock, forced to 0 while `ba_oe_n` is 1.
- R11: The two directions share no storage. The controls of one path never affect the other path.
- R12: While `rst_n` is low, both stored values and both strobe histories clear to 0, so the clock outputs read 0. A strobe that is high in the first cycle after reset counts as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all controls sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Local bus value seen by the A-to-B path |
| a_out | output | W | Stored B-to-A value for the local bus |
| a_oe | output | 1 | Local bus drive enable |
| b_in | input | W | Resolved backplane wire value seen by the B-to-A path |
| b_pull | output | W | Per-bit pull-low enable onto the backplane |
| ab_pass | input | 1 | A-to-B pass control, high = transparent |
| ab_cap_n | input | 1 | A-to-B capture enable, active low |
| ab_strobe | input | 1 | A-to-B capture strobe |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_pass | input | 1 | B-to-A pass control, high = transparent |
| ba_cap_n | input | 1 | B-to-A capture enable, active low |
| ba_strobe | input | 1 | B-to-A capture strobe |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_clk_out | output | 1 | Forwarded A-to-B strobe for the backplane |
| a_clk_out | output | 1 | Forwarded B-to-A strobe for the local side |

## Verification
Two events can land in the same cycle in this block. The first is a pass control falling on the same clock edge as a strobe rise with the capture enable asserted, which tests the ordering between the latch and the clocked capture. The second is a clocked capture together with the rise of the forwarded clock, which tests that the clock never leads its data. The bench steps pass, latch and strobe patterns, including the edge where the pass control falls while the strobe rises. It then runs a long random mix that overlaps both paths. On every clock it compares each output with a behavioural model, and the B-to-A path reads the resolved backplane wire, which the bench also pulls low at random.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    ST_KEEP    = 2'd0,
    ST_PASS    = 2'd1,
    ST_CAPTURE = 2'd2
  } store_mode_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pass,
  input  logic         cap_n,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         strobe_d
);
  logic [W-1:0] held;
  logic         strobe_q;
  logic         strobe_edge;
  store_mode_e  mode;

  assign strobe_edge = strobe & ~strobe_q;

  always_comb begin
    if (pass)                      mode = ST_PASS;
    else if (strobe_edge && !cap_n) mode = ST_CAPTURE;
    else                           mode = ST_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (mode != ST_KEEP) held <= d;
    end
  end

  assign q        = pass ? d : held;
  assign strobe_d = strobe_q;

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pass) && !pass) |-> (q == $past(d)));

  assert_clocked_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && !cap_n && strobe && !strobe_q) |=> (pass || q == $past(d)));

  assert_gated_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && cap_n) |=> (pass || $stable(q)));

  assert_idle_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && !strobe) |=> (pass || $stable(q)));
endmodule

// File: rtl/xcvr_clk_fwd.sv
module xcvr_clk_fwd (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_d,
  input  logic oe_n,
  output logic clk_out
);
  assign clk_out = strobe_d & ~oe_n;

  assert_fwd_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !clk_out);
endmodule

// File: rtl/xcvr_bidir.sv
module xcvr_bidir #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_pull,
  input  logic         ab_pass,
  input  logic         ab_cap_n,
  input  logic         ab_strobe,
  input  logic         ab_oe_n,
  input  logic         ba_pass,
  input  logic         ba_cap_n,
  input  logic         ba_strobe,
  input  logic         ba_oe_n,
  output logic         b_clk_out,
  output logic         a_clk_out
);
  logic [W-1:0] ab_q;
  logic [W-1:0] ba_q;
  logic         ab_strobe_d;
  logic         ba_strobe_d;

  xcvr_store #(.W(W)) u_ab_store (
    .clk(clk), .rst_n(rst_n), .pass(ab_pass), .cap_n(ab_cap_n),
    .strobe(ab_strobe), .d(a_in), .q(ab_q), .strobe_d(ab_strobe_d)
  );

  xcvr_store #(.W(W)) u_ba_store (
    .clk(clk), .rst_n(rst_n), .pass(ba_pass), .cap_n(ba_cap_n),
    .strobe(ba_strobe), .d(b_in), .q(ba_q), .strobe_d(ba_strobe_d)
  );

  xcvr_clk_fwd u_b_clk (
    .clk(clk), .rst_n(rst_n), .strobe_d(ab_strobe_d), .oe_n(ab_oe_n),
    .clk_out(b_clk_out)
  );

  xcvr_clk_fwd u_a_clk (
    .clk(clk), .rst_n(rst_n), .strobe_d(ba_strobe_d), .oe_n(ba_oe_n),
    .clk_out(a_clk_out)
  );

  for (genvar i = 0; i < W; i++) begin : g_b_drv
    assign b_pull[i] = ~ab_oe_n & ~ab_q[i];
  end

  assign a_out = ba_q;
  assign a_oe  = ~ba_oe_n;

  assert_b_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ab_oe_n |-> (b_pull == '0));

  assert_clk_not_ahead_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(b_clk_out) && !ab_pass && $past(!ab_pass) && $past(!ab_cap_n) &&
     $past(!ab_oe_n)) |-> (~b_pull == $past(a_in)));

  assert_a_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ba_oe_n |-> !a_oe);
endmodule

// File: tb/xcvr_bidir_tb_top.sv
`timescale 1ns/1ps
module xcvr_bidir_tb_top;
  localparam int W = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a_in = '0, ext_pull = '0;
  logic ab_pass = 0, ab_cap_n = 1, ab_strobe = 0, ab_oe_n = 1;
  logic ba_pass = 0, ba_cap_n = 1, ba_strobe = 0, ba_oe_n = 1;
  logic [W-1:0] a_out, b_pull, b_line;
  logic a_oe, b_clk_out, a_clk_out;

  assign b_line = ~(b_pull | ext_pull);

  xcvr_bidir #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_line), .b_pull(b_pull), .ab_pass(ab_pass), .ab_cap_n(ab_cap_n),
    .ab_strobe(ab_strobe), .ab_oe_n(ab_oe_n), .ba_pass(ba_pass),
    .ba_cap_n(ba_cap_n), .ba_strobe(ba_strobe), .ba_oe_n(ba_oe_n),
    .b_clk_out(b_clk_out), .a_clk_out(a_clk_out)
  );

  // behavioural reference
  logic [W-1:0] m_ab, m_ba, e_ab_q, e_ba_q, e_pull, e_line;
  logic m_ab_prev, m_ba_prev;
  always_comb begin
    e_ab_q = ab_pass ? a_in : m_ab;
    e_pull = ab_oe_n ? '0 : ~e_ab_q;
    e_line = ~(e_pull | ext_pull);
    e_ba_q = ba_pass ? e_line : m_ba;
  end
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ab = '0; m_ba = '0; m_ab_prev = 0; m_ba_prev = 0;
    end else begin
      if (ab_pass || (ab_strobe && !m_ab_prev && !ab_cap_n)) m_ab = a_in;
      if (ba_pass || (ba_strobe && !m_ba_prev && !ba_cap_n)) m_ba = e_line;
      m_ab_prev = ab_strobe;
      m_ba_prev = ba_strobe;
    end
  end

  int checks = 0, failures = 0;

  task automatic cmp(input string tag, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s/%s actual=%h expected=%h", tag, req, act, exp);
    end
  endtask

  task automatic step(input string tag);
    #1;
    cmp(tag, "R7", 32'(a_out), 32'(e_ba_q));
    cmp(tag, "R7", 32'(a_oe), 32'(!ba_oe_n));
    cmp(tag, "R8", 32'(b_pull), 32'(e_pull));
    cmp(tag, "R9", 32'(b_clk_out), 32'(m_ab_prev & !ab_oe_n));
    cmp(tag, "R10", 32'(a_clk_out), 32'(m_ba_prev & !ba_oe_n));
    @(posedge clk); #1;
  endtask

  function automatic logic [W-1:0] rnd();
    return W'($urandom);
  endfunction

  initial begin
    #1000000;
    failures++; checks++;
    $display("FAIL R12 watchdog actual=expired expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state, all stored values zero and clocks low
    cmp("R12", "R12", 32'(a_out), 32'd0);
    cmp("R12", "R12", 32'(b_pull), 32'd0);
    cmp("R12", "R12", 32'(b_clk_out | a_clk_out), 32'd0);
    // R1: width of both paths
    cmp("R1", "R1", 32'($bits(a_out) + $bits(b_pull)), 32'(2 * 17));
    rst_n = 1;
    @(posedge clk); #1;
    step("R12");

    ab_oe_n = 0; ba_oe_n = 0; ab_pass = 1; ba_pass = 1;
    for (int i = 0; i < 6; i++) begin a_in = rnd(); ext_pull = rnd(); step("R2"); end

    ab_pass = 0; ba_pass = 0;
    for (int i = 0; i < 6; i++) begin a_in = rnd(); ext_pull = rnd(); step("R3"); end

    ab_cap_n = 0; ba_cap_n = 0;
    for (int i = 0; i < 10; i++) begin
      a_in = rnd(); ext_pull = rnd();
      ab_strobe = ~ab_strobe; ba_strobe = (i % 3) == 0; step("R4");
    end

    ab_cap_n = 1; ba_cap_n = 1;
    for (int i = 0; i < 8; i++) begin
      a_in = rnd(); ext_pull = rnd();
      ab_strobe = ~ab_strobe; ba_strobe = ~ba_strobe; step("R5");
    end

    ab_cap_n = 0; ba_cap_n = 0; ab_strobe = 0; ba_strobe = 0;
    ab_pass = 1; ba_pass = 1;
    for (int i = 0; i < 4; i++) begin
      a_in = rnd(); ext_pull = rnd();
      ab_strobe = ~ab_strobe; ba_strobe = ~ba_strobe; step("R6");
    end
    // pass falls on the edge where the strobe rises
    ab_strobe = 0; ba_strobe = 0; a_in = rnd(); step("R6");
    ab_pass = 0; ba_pass = 0; ab_strobe = 1; ba_strobe = 1; a_in = rnd(); step("R3");
    a_in = rnd(); step("R3");

    for (int i = 0; i < 12; i++) begin
      a_in = rnd(); ext_pull = rnd();
      ab_oe_n = 1'($urandom); ba_oe_n = 1'($urandom);
      ab_strobe = ~ab_strobe; ba_strobe = 1'($urandom); step("R8");
    end

    for (int i = 0; i < 400; i++) begin
      a_in = rnd(); ext_pull = ($urandom % 4 == 0) ? rnd() : '0;
      ab_pass = ($urandom % 5) == 0; ba_pass = ($urandom % 5) == 0;
      ab_cap_n = 1'($urandom); ba_cap_n = 1'($urandom);
      ab_strobe = 1'($urandom); ba_strobe = 1'($urandom);
      ab_oe_n = ($urandom % 6) == 0; ba_oe_n = ($urandom % 6) == 0;
      step("R11");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule